// File: doc/BRIEF.md
# DMA Page Translator

This block sits between a DMA engine and system memory and turns each 24-bit logical DMA address into a 29-bit physical address. The mapping lives in a page table in memory. Each table entry is one 32-bit word, and each page is 4 KB. Software programs two values through a small write-only register port: the byte address of the table and the table size in bytes. A write to a third register discards every translation held on chip.

For each request, the block first compares the byte offset of the table entry against the size limit. An entry outside the table is refused. An entry inside the table is looked up in a four-slot, fully associative cache. On a miss, the block fetches the entry over a simple read port and stalls the requester until the word returns. The physical frame from the entry is then joined with the untouched 12-bit page offset.

The control is one state machine with three states:
- `ST_IDLE` accepts a request. It goes to `ST_RESP` on a bound error or a cache hit, and to `ST_FETCH` on a miss.
- `ST_FETCH` holds the read request. It goes to `ST_RESP` when the read is acknowledged.
- `ST_RESP` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `dmatr_xlate`

## Requirements
- R1: After reset:
  - `req_ready` is 1.
  - `resp_valid` and `tbl_rd_req` are 0.
  - Both failure-address outputs are 0.
  - Base and limit are 0, so every access is refused.
- R2: A translated address is formed from two parts:
  - Bits [11:0] are the logical bits [11:0].
  - Bits [28:12] are bits [28:12] of the table word. Table word bits [31:29] and [11:0] are ignored.
- R3: On a miss, `tbl_rd_addr` is base + 4 × logical bits [23:12], modulo 2^32. `tbl_rd_req` stays high with a stable address until `tbl_rd_ack`. `req_ready` is low from acceptance until the response has been presented.
- R4: A write with `cfg_wr` high selects its target by `cfg_sel`:
  - 0 writes the base.
  - 1 writes the limit.
  - 2 invalidates the cache; the data is ignored.
  - 3 has no effect.
- R5: If 4 × page index ≥ limit, the access is refused and no memory read is made:
  - `resp_bound_err` is 1.
  - `bound_fail_addr` latches the logical address.
  - This check takes priority over a cache hit.
- R6: A page whose translation is cached is answered without a memory read.
- R7: The cache holds 4 pages. Fills go to slots in round-robin order starting at slot 0, so a fifth distinct page evicts the oldest fill.
- R8: An invalidate write discards all cached pages and returns the fill order to slot 0. The next access to any page misses.
- R9: If `tbl_rd_err` is high with the acknowledge:
  - `resp_mem_fault` is 1.
  - `mem_fail_addr` latches the table-entry address.
  - Nothing is cached.
- R10: If an invalidate write falls in the same cycle as a fetch completes, the invalidate wins. The response still carries the fetched translation, but the page is not cached.
- R11: `resp_valid` is high for exactly one cycle:
  - For a hit or a bound error, it is the cycle after acceptance.
  - For a miss, it is the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 limit, 2 invalidate) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 24 | Logical address |
| req_ready | output | 1 | Request accepted this cycle when high |
| resp_valid | output | 1 | Result present |
| resp_paddr | output | 29 | Physical address |
| resp_bound_err | output | 1 | Entry outside table |
| resp_mem_fault | output | 1 | Table read failed |
| tbl_rd_req | output | 1 | Table read request |
| tbl_rd_addr | output | 32 | Table-entry byte address |
| tbl_rd_ack | input | 1 | Table read completes |
| tbl_rd_data | input | 32 | Table word |
| tbl_rd_err | input | 1 | Table read failed |
| bound_fail_addr | output | 24 | Last refused logical address |
| mem_fail_addr | output | 32 | Last failing table-entry address |

## Verification
The invalidate register write and the cache fill at the end of a fetch can land on the same clock edge. The bench provokes this by raising `cfg_wr` with select 2 in the same cycle it returns `tbl_rd_ack`. It judges the result in two ways: the response must still carry the fetched frame, and a second access to that page must show a fresh table read. The bench also makes a cached page fall outside a reduced limit, which checks that the bound test wins over a hit.

// File: rtl/dmatr_pkg.sv
package dmatr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_FLUSH = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/dmatr_regs.sv
module dmatr_regs
    import dmatr_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] base_o,
    output logic [REG_W-1:0] limit_o,
    output logic             flush_o
);
    // Flush acts in the write cycle so it can meet a fill on the same edge.
    assign flush_o = wr && (cfg_sel_e'(sel) == SEL_FLUSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o  <= '0;
            limit_o <= '0;
        end else if (wr) begin
            if (cfg_sel_e'(sel) == SEL_BASE)  base_o  <= wdata;
            if (cfg_sel_e'(sel) == SEL_LIMIT) limit_o <= wdata;
        end
    end
endmodule

// File: rtl/dmatr_tcache.sv
module dmatr_tcache #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 12,
    parameter int DATA_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              flush
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [PTR_W-1:0]   ptr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) hit_data = hit_data | data_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[ptr_q]  <= fill_tag;
            data_q[ptr_q] <= fill_data;
        end
    end

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    assert_hit_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    assert_fill_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && (valid_q != '1)) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
endmodule

// File: rtl/dmatr_xlate.sv
module dmatr_xlate
    import dmatr_pkg::*;
#(
    parameter int LADDR_W       = 24,
    parameter int PADDR_W       = 29,
    parameter int PAGE_BITS     = 12,
    parameter int REG_W         = 32,
    parameter int CACHE_ENTRIES = 4,
    parameter int ENTRY_SHIFT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_laddr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [PADDR_W-1:0] resp_paddr,
    output logic               resp_bound_err,
    output logic               resp_mem_fault,
    output logic               tbl_rd_req,
    output logic [REG_W-1:0]   tbl_rd_addr,
    input  logic               tbl_rd_ack,
    input  logic [REG_W-1:0]   tbl_rd_data,
    input  logic               tbl_rd_err,
    output logic [LADDR_W-1:0] bound_fail_addr,
    output logic [REG_W-1:0]   mem_fail_addr
);
    localparam int IDX_W = LADDR_W - PAGE_BITS;
    localparam int PFN_W = PADDR_W - PAGE_BITS;

    xl_state_e state_q, state_d;

    logic [REG_W-1:0]   base, limit;
    logic               flush;
    logic [IDX_W-1:0]   idx;
    logic [REG_W-1:0]   ent_off;
    logic               bound_bad, hit, fill_en, accept;
    logic [PFN_W-1:0]   hit_pfn;
    logic [LADDR_W-1:0] laddr_q;
    logic [REG_W-1:0]   fetch_addr_q;

    wire unused_tbl_bits = ^{tbl_rd_data[REG_W-1:PADDR_W], tbl_rd_data[PAGE_BITS-1:0]};

    dmatr_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .base_o(base), .limit_o(limit), .flush_o(flush)
    );

    assign idx       = req_laddr[LADDR_W-1:PAGE_BITS];
    assign ent_off   = REG_W'(idx) << ENTRY_SHIFT;
    assign bound_bad = (ent_off >= limit);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign fill_en   = (state_q == ST_FETCH) && tbl_rd_ack && !tbl_rd_err;

    dmatr_tcache #(.ENTRIES(CACHE_ENTRIES), .TAG_W(IDX_W), .DATA_W(PFN_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .look_tag(idx), .hit(hit), .hit_data(hit_pfn),
        .fill_en(fill_en), .fill_tag(laddr_q[LADDR_W-1:PAGE_BITS]),
        .fill_data(tbl_rd_data[PADDR_W-1:PAGE_BITS]), .flush(flush)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (bound_bad || hit) ? ST_RESP : ST_FETCH;
            ST_FETCH: if (tbl_rd_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        tbl_rd_req = (state_q == ST_FETCH);
        resp_valid = (state_q == ST_RESP);
    end

    assign tbl_rd_addr = fetch_addr_q;

    // Result and failure-address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            laddr_q         <= '0;
            fetch_addr_q    <= '0;
            resp_paddr      <= '0;
            resp_bound_err  <= 1'b0;
            resp_mem_fault  <= 1'b0;
            bound_fail_addr <= '0;
            mem_fail_addr   <= '0;
        end else if (accept) begin
            laddr_q        <= req_laddr;
            resp_bound_err <= bound_bad;
            resp_mem_fault <= 1'b0;
            if (bound_bad)
                bound_fail_addr <= req_laddr;
            else if (hit)
                resp_paddr <= {hit_pfn, req_laddr[PAGE_BITS-1:0]};
            else
                fetch_addr_q <= base + ent_off;
        end else if ((state_q == ST_FETCH) && tbl_rd_ack) begin
            if (tbl_rd_err) begin
                resp_mem_fault <= 1'b1;
                mem_fail_addr  <= fetch_addr_q;
            end else begin
                resp_paddr <= {tbl_rd_data[PADDR_W-1:PAGE_BITS], laddr_q[PAGE_BITS-1:0]};
            end
        end
    end

    assert_hold_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_req && !tbl_rd_ack) |=> (tbl_rd_req && $stable(tbl_rd_addr)));
    assert_no_read_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tbl_rd_req);
    assert_bound_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bound_bad) |=> (!tbl_rd_req && resp_valid && resp_bound_err));
    assert_fault_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_req && tbl_rd_ack && tbl_rd_err) |=> (resp_mem_fault && mem_fail_addr == $past(tbl_rd_addr)));
    assert_one_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));
    assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_bound_err && resp_mem_fault));
endmodule

// File: tb/tb_dmatr_xlate.sv
module tb_dmatr_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [23:0] req_laddr = '0;
    logic        req_ready, resp_valid, resp_bound_err, resp_mem_fault, tbl_rd_req;
    logic [28:0] resp_paddr;
    logic [31:0] tbl_rd_addr, mem_fail_addr;
    logic        tbl_rd_ack = 1'b0, tbl_rd_err = 1'b0;
    logic [31:0] tbl_rd_data = '0;
    logic [23:0] bound_fail_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmatr_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_bound_err(resp_bound_err),
        .resp_mem_fault(resp_mem_fault), .tbl_rd_req(tbl_rd_req), .tbl_rd_addr(tbl_rd_addr),
        .tbl_rd_ack(tbl_rd_ack), .tbl_rd_data(tbl_rd_data), .tbl_rd_err(tbl_rd_err),
        .bound_fail_addr(bound_fail_addr), .mem_fail_addr(mem_fail_addr)
    );

    int total = 0;
    int bad = 0;

    // Behavioural reference state
    logic [31:0] m_base = '0, m_limit = '0;
    logic [11:0] m_tag [4];
    logic [16:0] m_pfn [4];
    bit          m_val [4] = '{0, 0, 0, 0};
    int          m_ptr = 0;
    logic [23:0] m_bfail = '0;
    logic [31:0] m_mfail = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] frame_of(logic [31:0] a);
        return a[18:2] ^ 17'h15A3C;
    endfunction

    function automatic int m_find(logic [11:0] t);
        for (int i = 0; i < 4; i++)
            if (m_val[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic m_flush();
        for (int i = 0; i < 4; i++) m_val[i] = 0;
        m_ptr = 0;
    endtask

    task automatic cfg(logic [1:0] sel, logic [31:0] data, string req);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(req, "ready after write", 32'(req_ready), 32'd1);
        chk(req, "no resp after write", 32'(resp_valid), 32'd0);
        case (sel)
            2'd0: m_base = data;
            2'd1: m_limit = data;
            2'd2: m_flush();
            default: ;
        endcase
    endtask

    task automatic xlat(logic [23:0] la, bit fault, bit flush_at_ack, string req);
        logic [11:0] idx = la[23:12];
        logic [31:0] off = {18'd0, idx, 2'b00};
        logic [31:0] ea  = m_base + off;
        bit          oob = (off >= m_limit);
        int          slot = m_find(idx);
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "ready low after accept", 32'(req_ready), 32'd0);
        if (oob || slot >= 0) begin
            chk(req, "resp next cycle", 32'(resp_valid), 32'd1);
            chk(req, "no table read", 32'(tbl_rd_req), 32'd0);
            chk(req, "bound err", 32'(resp_bound_err), 32'(oob));
            chk(req, "mem fault", 32'(resp_mem_fault), 32'd0);
            if (oob) m_bfail = la;
            else chk(req, "hit paddr", 32'(resp_paddr), 32'({m_pfn[slot], la[11:0]}));
            chk(req, "bound fail addr", 32'(bound_fail_addr), 32'(m_bfail));
        end else begin
            for (int k = 0; k < MEM_LAT; k++) begin
                chk(req, "read held", 32'(tbl_rd_req), 32'd1);
                chk(req, "read addr", tbl_rd_addr, ea);
                chk(req, "no resp while fetching", 32'(resp_valid), 32'd0);
                @(negedge clk);
            end
            chk(req, "read addr at ack", tbl_rd_addr, ea);
            tbl_rd_ack = 1'b1; tbl_rd_err = fault;
            tbl_rd_data = {3'b101, frame_of(ea), 12'h7E5};
            if (flush_at_ack) begin
                cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h1234_5678;
            end
            @(negedge clk);
            tbl_rd_ack = 1'b0; tbl_rd_err = 1'b0; cfg_wr = 1'b0;
            chk(req, "resp after ack", 32'(resp_valid), 32'd1);
            chk(req, "bound err", 32'(resp_bound_err), 32'd0);
            chk(req, "mem fault", 32'(resp_mem_fault), 32'(fault));
            if (fault) begin
                m_mfail = ea;
            end else begin
                chk(req, "miss paddr", 32'(resp_paddr), 32'({frame_of(ea), la[11:0]}));
                if (!flush_at_ack) begin
                    m_tag[m_ptr] = idx; m_pfn[m_ptr] = frame_of(ea); m_val[m_ptr] = 1;
                    m_ptr = (m_ptr + 1) % 4;
                end
            end
            if (flush_at_ack) m_flush();
            chk(req, "mem fail addr", mem_fail_addr, m_mfail);
        end
        @(negedge clk);
        chk("R11", "resp one cycle", 32'(resp_valid), 32'd0);
        chk("R11", "ready again", 32'(req_ready), 32'd1);
        chk("R3", "no read when idle", 32'(tbl_rd_req), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "resp_valid", 32'(resp_valid), 32'd0);
        chk("R1", "tbl_rd_req", 32'(tbl_rd_req), 32'd0);
        chk("R1", "bound fail", 32'(bound_fail_addr), 32'd0);
        chk("R1", "mem fail", mem_fail_addr, 32'd0);
        xlat(24'h000123, 0, 0, "R1 R5 limit zero");

        cfg(2'd0, 32'h1000_0000, "R4 base");
        cfg(2'd1, 32'h0000_8000, "R4 limit");
        xlat(24'h123456, 0, 0, "R3 R2 miss");
        xlat(24'h123ABC, 0, 0, "R6 hit");
        xlat(24'h000010, 0, 0, "R7 fill1");
        xlat(24'h7FF001, 0, 0, "R7 fill2");
        xlat(24'hFFFFFF, 0, 0, "R7 fill3 top page");
        xlat(24'h555000, 0, 0, "R7 evict oldest");
        xlat(24'h123000, 0, 0, "R7 evicted misses");
        xlat(24'h7FF777, 0, 0, "R7 survivor hits");
        xlat(24'h000020, 0, 0, "R7 second evict");

        cfg(2'd2, 32'h0, "R8 invalidate");
        xlat(24'h7FF000, 0, 0, "R8 miss after flush");

        cfg(2'd3, 32'hFFFF_FFFF, "R4 unused select");
        xlat(24'h7FF123, 0, 0, "R4 cache kept");
        xlat(24'h400000, 0, 0, "R4 base kept");

        xlat(24'h0AB000, 1, 0, "R9 fault");
        xlat(24'h0AB004, 0, 0, "R9 not cached");

        xlat(24'h0CD000, 0, 1, "R10 flush at fill");
        xlat(24'h0CD100, 0, 0, "R10 refetch");

        cfg(2'd1, 32'h0000_0040, "R5 small limit");
        xlat(24'h00F000, 0, 0, "R5 last inside");
        xlat(24'h010000, 0, 0, "R5 first outside");
        xlat(24'h0CD200, 0, 0, "R5 bound over hit");

        cfg(2'd0, 32'hFFFF_FFF0, "R3 base wrap");
        xlat(24'h00E000, 0, 0, "R3 wrapped address");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule